// File: doc/BRIEF.md
# Interrupt Stacking and Return Sequencer

This block saves and restores an 8-bit processor's state through a byte-wide stack in memory. When the core executes a software interrupt or a trap, or when a hardware request is accepted, the sequencer writes the return address, the index register X, the accumulators A and B and the flag byte to the stack. It then sets the interrupt mask bit, reads a 16-bit handler address from a fixed table at the top of memory, and presents it as the new program counter. A return request runs the reverse: every saved byte is pulled back, including the flag byte with its mask bit, and execution resumes at the saved address.

The core supplies its live registers and stack pointer on the input ports and takes the results from the output ports in the cycle where `done` is high. The memory port is synchronous: a write happens at the clock edge where `mem_we` is high, and read data appears one cycle after the address. A non-maskable request that comes in while a sequence is running is held and started as soon as that sequence ends.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset `busy`, `done` and `mem_we` are low and every register output reads zero; `mem_we` is never high while `busy` is low.
- R2: A push writes at the current stack address and then lowers it by one. A full entry makes 7 pushes at 7 consecutive descending addresses, and `sp_out` ends at `sp_in` minus 7.
- R3: With S as `sp_in`, an entry stores PC low at S, PC high at S-1, X low at S-2, X high at S-3, A at S-4, B at S-5 and the flag byte at S-6. The stored flag byte is the value from before entry.
- R4: The handler address is read high byte first from the vector address and low byte from the next one. The vector addresses are 0xFFFA for a software interrupt, 0xFFFC for a trap, 0xFFF8 for a maskable request and 0xFFFE for a non-maskable request.
- R5: The mask bit is bit 4 of the flag byte. After an entry `ccr_out` equals the old flag byte with bit 4 set.
- R6: While `ccr_in` bit 4 is set, a maskable request starts nothing. A non-maskable request is taken regardless of that bit.
- R7: On return, each pull raises the stack address by one and then reads there. The order is flags, B, A, X high, X low, PC high, PC low. Every output, including flag bit 4, takes the pulled value, and `sp_out` ends at `sp_in` plus 7.
- R8: A non-maskable request pulsed while a sequence is running is latched. Its entry starts in the clock edge that ends the `done` cycle.
- R9: `busy` is high for exactly 10 cycles per entry and 8 cycles per return. `done` is a single-cycle pulse that follows them.
- R10: When starts coincide, the priority is non-maskable, then maskable, then software interrupt, then trap, then return. A software interrupt, trap or return start seen while `busy` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| swi_start | input | 1 | Software interrupt start pulse |
| trap_start | input | 1 | Trap start pulse |
| rti_start | input | 1 | Return-from-interrupt start pulse |
| irq_req | input | 1 | Maskable hardware request (level) |
| nmi_req | input | 1 | Non-maskable request pulse |
| pc_in | input | 16 | Return address to save |
| x_in | input | 16 | Index register to save |
| a_in | input | 8 | Accumulator A to save |
| b_in | input | 8 | Accumulator B to save |
| ccr_in | input | 8 | Flag byte; bit 4 is the mask |
| sp_in | input | 16 | Stack pointer at start |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter |
| x_out | output | 16 | X after the sequence |
| a_out | output | 8 | A after the sequence |
| b_out | output | 8 | B after the sequence |
| ccr_out | output | 8 | Flag byte after the sequence |
| sp_out | output | 16 | Stack pointer after the sequence |

## Verification
The bench reads back each stacked byte at its exact address. A design that swapped the halves of a 16-bit push, or wrote before decrementing in the wrong direction, would leave the return address or X scrambled and off by one slot. It pulls a frame whose saved mask bit is clear, which catches a design that forces the mask on return. It also checks that a masked maskable request leaves `busy` low while a non-maskable one still starts. It pulses a non-maskable request mid-entry and expects a second entry in the cycle after `done`, so a design that drops the pulse or restarts the first sequence is caught. Coincident starts and starts made while busy confirm the priority order and that stray starts do not queue.

// File: rtl/irq_seq_pkg.sv
// Package: shared types for the interrupt stacking sequencer.
// Assumes byte-wide memory and 16-bit addresses and index register.
package irq_seq_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int STEP_W = 3;
    localparam int PUSH_BYTES = 7;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PUSH,
        SEQ_VEC,
        SEQ_PULL
    } seq_state_t;

    typedef enum logic [2:0] {
        SRC_NMI,
        SRC_IRQ,
        SRC_SWI,
        SRC_TRAP,
        SRC_RTI
    } seq_src_t;
endpackage

// File: rtl/irq_seq_arb.sv
// Module: start arbiter with non-maskable latch.
// Chooses one start source when the sequencer is idle, by fixed priority
// (non-maskable, maskable, software, trap, return). Holds a non-maskable
// pulse that arrives while busy until it can be started.
module irq_seq_arb
    import irq_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     idle,
    input  logic     nmi_req,
    input  logic     irq_req,
    input  logic     i_mask,
    input  logic     swi_start,
    input  logic     trap_start,
    input  logic     rti_start,
    output logic     take,
    output seq_src_t src,
    output logic     nmi_pend
);
    logic nmi_any;
    logic take_nmi;

    assign nmi_any  = nmi_pend | nmi_req;
    assign take_nmi = idle & nmi_any;

    // Priority choice of the start source.
    always_comb begin
        take = 1'b0;
        src  = SRC_RTI;
        if (idle) begin
            if (nmi_any) begin
                take = 1'b1; src = SRC_NMI;
            end else if (irq_req && !i_mask) begin
                take = 1'b1; src = SRC_IRQ;
            end else if (swi_start) begin
                take = 1'b1; src = SRC_SWI;
            end else if (trap_start) begin
                take = 1'b1; src = SRC_TRAP;
            end else if (rti_start) begin
                take = 1'b1; src = SRC_RTI;
            end
        end
    end

    // Latch a non-maskable pulse until an entry for it starts.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_pend <= 1'b0;
        else        nmi_pend <= nmi_any & ~take_nmi;
    end
endmodule

// File: rtl/irq_seq_pushsel.sv
// Module: push byte selector.
// Returns the byte to store at push step 0..6. The order is PC low, PC high,
// X low, X high, A, B, flags. Purely combinational.
module irq_seq_pushsel
    import irq_seq_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic [WORD_W-1:0] pc,
    input  logic [WORD_W-1:0] x,
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  logic [BYTE_W-1:0] flags,
    output logic [BYTE_W-1:0] byte_out
);
    logic [BYTE_W-1:0] frame [PUSH_BYTES];

    // Build the frame in push order.
    always_comb begin
        frame[0] = pc[BYTE_W-1:0];
        frame[1] = pc[WORD_W-1:BYTE_W];
        frame[2] = x[BYTE_W-1:0];
        frame[3] = x[WORD_W-1:BYTE_W];
        frame[4] = a;
        frame[5] = b;
        frame[6] = flags;
    end

    // Index the frame; out-of-range steps give zero.
    always_comb begin
        byte_out = '0;
        for (int i = 0; i < PUSH_BYTES; i++)
            if (step == STEP_W'(i)) byte_out = frame[i];
    end
endmodule

// File: rtl/irq_stack_seq.sv
// Module: interrupt stacking and return sequencer (top).
// On entry it pushes PC, X, A, B and flags with post-decrement, sets the
// mask bit, and reads a 16-bit vector high byte first. On return it pulls the
// frame back with pre-increment. Assumes memory read data arrives one cycle
// after the address, and that the register inputs are stable at start.
module irq_stack_seq
    import irq_seq_pkg::*;
#(
    parameter logic [15:0] VEC_SWI  = 16'hFFFA,
    parameter logic [15:0] VEC_TRAP = 16'hFFFC,
    parameter logic [15:0] VEC_IRQ  = 16'hFFF8,
    parameter logic [15:0] VEC_NMI  = 16'hFFFE,
    parameter int          I_BIT    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        swi_start,
    input  logic        trap_start,
    input  logic        rti_start,
    input  logic        irq_req,
    input  logic        nmi_req,
    input  logic [15:0] pc_in,
    input  logic [15:0] x_in,
    input  logic [7:0]  a_in,
    input  logic [7:0]  b_in,
    input  logic [7:0]  ccr_in,
    input  logic [15:0] sp_in,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] pc_out,
    output logic [15:0] x_out,
    output logic [7:0]  a_out,
    output logic [7:0]  b_out,
    output logic [7:0]  ccr_out,
    output logic [15:0] sp_out
);
    localparam logic [STEP_W-1:0] LAST_PUSH = STEP_W'(PUSH_BYTES - 1);
    localparam logic [STEP_W-1:0] LAST_PULL = STEP_W'(PUSH_BYTES);
    localparam logic [BYTE_W-1:0] MASK_SET  = BYTE_W'(1) << I_BIT;

    seq_state_t        state;
    logic [STEP_W-1:0] step;
    logic [WORD_W-1:0] vec_r;
    logic [BYTE_W-1:0] vec_hi;
    logic [BYTE_W-1:0] saved_ccr;
    logic [BYTE_W-1:0] push_byte;
    logic              take;
    seq_src_t          src;
    logic              nmi_pend;
    logic [WORD_W-1:0] vec_sel;

    assign busy = (state != SEQ_IDLE);

    irq_seq_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (!busy),
        .nmi_req    (nmi_req),
        .irq_req    (irq_req),
        .i_mask     (ccr_in[I_BIT]),
        .swi_start  (swi_start),
        .trap_start (trap_start),
        .rti_start  (rti_start),
        .take       (take),
        .src        (src),
        .nmi_pend   (nmi_pend)
    );

    irq_seq_pushsel u_psel (
        .step     (step),
        .pc       (pc_out),
        .x        (x_out),
        .a        (a_out),
        .b        (b_out),
        .flags    (saved_ccr),
        .byte_out (push_byte)
    );

    // Vector address for the chosen source.
    always_comb begin
        case (src)
            SRC_NMI:  vec_sel = VEC_NMI;
            SRC_IRQ:  vec_sel = VEC_IRQ;
            SRC_TRAP: vec_sel = VEC_TRAP;
            default:  vec_sel = VEC_SWI;
        endcase
    end

    // Memory bus drive for the current step.
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        case (state)
            SEQ_PUSH: begin
                mem_addr  = sp_out;
                mem_wdata = push_byte;
                mem_we    = 1'b1;
            end
            SEQ_VEC:  mem_addr = (step == '0) ? vec_r : vec_r + 16'd1;
            SEQ_PULL: mem_addr = sp_out + 16'd1;
            default:  mem_addr = '0;
        endcase
    end

    // Sequencer state, working registers and captures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            step      <= '0;
            vec_r     <= '0;
            vec_hi    <= '0;
            saved_ccr <= '0;
            done      <= 1'b0;
            pc_out    <= '0;
            x_out     <= '0;
            a_out     <= '0;
            b_out     <= '0;
            ccr_out   <= '0;
            sp_out    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    step <= '0;
                    if (take) begin
                        sp_out <= sp_in;
                        if (src == SRC_RTI) begin
                            state <= SEQ_PULL;
                        end else begin
                            state     <= SEQ_PUSH;
                            pc_out    <= pc_in;
                            x_out     <= x_in;
                            a_out     <= a_in;
                            b_out     <= b_in;
                            saved_ccr <= ccr_in;
                            ccr_out   <= ccr_in | MASK_SET;
                            vec_r     <= vec_sel;
                        end
                    end
                end
                SEQ_PUSH: begin
                    sp_out <= sp_out - 16'd1;
                    if (step == LAST_PUSH) begin
                        state <= SEQ_VEC;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                SEQ_VEC: begin
                    step <= step + 1'b1;
                    if (step == STEP_W'(1)) vec_hi <= mem_rdata;
                    if (step == STEP_W'(2)) begin
                        pc_out <= {vec_hi, mem_rdata};
                        done   <= 1'b1;
                        state  <= SEQ_IDLE;
                    end
                end
                SEQ_PULL: begin
                    if (step != LAST_PULL) sp_out <= sp_out + 16'd1;
                    case (step)
                        STEP_W'(1): ccr_out <= mem_rdata;
                        STEP_W'(2): b_out   <= mem_rdata;
                        STEP_W'(3): a_out   <= mem_rdata;
                        STEP_W'(4): x_out[15:8] <= mem_rdata;
                        STEP_W'(5): x_out[7:0]  <= mem_rdata;
                        STEP_W'(6): pc_out[15:8] <= mem_rdata;
                        STEP_W'(7): pc_out[7:0]  <= mem_rdata;
                        default: ;
                    endcase
                    if (step == LAST_PULL) begin
                        done  <= 1'b1;
                        state <= SEQ_IDLE;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// Module: protocol checker for irq_stack_seq, attached by bind.
// Watches the bus, the mask handling and the latch for the non-maskable request.
module irq_stack_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic        irq_req,
    input logic        nmi_req,
    input logic        nmi_pend,
    input logic        swi_start,
    input logic        trap_start,
    input logic        rti_start,
    input logic [7:0]  ccr_in,
    input logic        vec_last,
    input logic [7:0]  ccr_out
);
    assert_idle_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

    assert_push_descends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));

    assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_last |=> ccr_out[4]);

    assert_masked_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && irq_req && ccr_in[4] && !nmi_req && !nmi_pend &&
         !swi_start && !trap_start && !rti_start) |=> !busy);

    assert_nmi_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && nmi_req) |=> nmi_pend);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind irq_stack_seq irq_stack_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .irq_req    (irq_req),
    .nmi_req    (nmi_req),
    .nmi_pend   (nmi_pend),
    .swi_start  (swi_start),
    .trap_start (trap_start),
    .rti_start  (rti_start),
    .ccr_in     (ccr_in),
    .vec_last   ((state == irq_seq_pkg::SEQ_VEC) && (step == 3'd2)),
    .ccr_out    (ccr_out)
);

// File: tb/tb_irq_stack_seq.sv
// Directed bench for irq_stack_seq: one task per scenario, each self-checking.
module tb_irq_stack_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        swi_start = 0, trap_start = 0, rti_start = 0;
    logic        irq_req = 0, nmi_req = 0;
    logic [15:0] pc_in = 0, x_in = 0, sp_in = 0;
    logic [7:0]  a_in = 0, b_in = 0, ccr_in = 0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata = 0;
    logic        busy, done;
    logic [15:0] pc_out, x_out, sp_out;
    logic [7:0]  a_out, b_out, ccr_out;

    int checks = 0;
    int errors = 0;
    int ticks  = 0;

    logic [7:0] mem [512];

    always #2.5 clk = ~clk;

    irq_stack_seq dut (
        .clk(clk), .rst_n(rst_n), .swi_start(swi_start), .trap_start(trap_start),
        .rti_start(rti_start), .irq_req(irq_req), .nmi_req(nmi_req),
        .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .b_in(b_in), .ccr_in(ccr_in),
        .sp_in(sp_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .pc_out(pc_out),
        .x_out(x_out), .a_out(a_out), .b_out(b_out), .ccr_out(ccr_out), .sp_out(sp_out)
    );

    function automatic int idx(input logic [15:0] ad);
        return {23'd0, ad[15], ad[7:0]};
    endfunction

    // Synchronous memory model: one-cycle read latency.
    always @(posedge clk) begin
        if (mem_we) mem[idx(mem_addr)] <= mem_wdata;
        mem_rdata <= mem[idx(mem_addr)];
    end

    // Watchdog.
    always @(posedge clk) begin
        ticks++;
        if (ticks > 20000) begin
            $display("FAIL watchdog: actual %0d cycles expected < 20000", ticks);
            errors++;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_regs(input logic [15:0] pc, input logic [15:0] x,
                            input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] f, input logic [15:0] sp);
        pc_in = pc; x_in = x; a_in = a; b_in = b; ccr_in = f; sp_in = sp;
    endtask

    // Wait for done; returns number of busy cycles seen.
    task automatic wait_done(output int nbusy);
        nbusy = 0;
        for (int k = 0; k < 60 && !done; k++) begin
            if (busy) nbusy++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 we", mem_we, 0);
        check("R1 pc", pc_out, 0);
        check("R1 sp", sp_out, 0);
    endtask

    task automatic t_swi_entry;
        int nb;
        mem[idx(16'hFFFA)] = 8'h80; mem[idx(16'hFFFB)] = 8'h10;
        set_regs(16'h1234, 16'hABCD, 8'h11, 8'h22, 8'hC5, 16'h00F0);
        pulse(swi_start);
        wait_done(nb);
        check("R9 entry busy", nb, 10);
        check("R9 done", done, 1);
        check("R3 pcl", mem[idx(16'h00F0)], 8'h34);
        check("R3 pch", mem[idx(16'h00EF)], 8'h12);
        check("R3 xl",  mem[idx(16'h00EE)], 8'hCD);
        check("R3 xh",  mem[idx(16'h00ED)], 8'hAB);
        check("R3 a",   mem[idx(16'h00EC)], 8'h11);
        check("R3 b",   mem[idx(16'h00EB)], 8'h22);
        check("R3 flags", mem[idx(16'h00EA)], 8'hC5);
        check("R2 sp", sp_out, 16'h00E9);
        check("R4 swi vec", pc_out, 16'h8010);
        check("R5 ccr", ccr_out, 8'hD5);
        @(negedge clk);
        check("R9 done pulse", done, 0);
    endtask

    task automatic t_rti;
        int nb;
        set_regs(16'h0, 16'h0, 8'h0, 8'h0, 8'hD0, 16'h00E9);
        pulse(rti_start);
        wait_done(nb);
        check("R9 return busy", nb, 8);
        check("R7 ccr incl mask", ccr_out, 8'hC5);
        check("R7 pc", pc_out, 16'h1234);
        check("R7 x", x_out, 16'hABCD);
        check("R7 a", a_out, 8'h11);
        check("R7 b", b_out, 8'h22);
        check("R7 sp", sp_out, 16'h00F0);
    endtask

    task automatic t_trap;
        int nb;
        mem[idx(16'hFFFC)] = 8'h9A; mem[idx(16'hFFFD)] = 8'hBC;
        set_regs(16'h4000, 16'h0102, 8'h33, 8'h44, 8'h00, 16'h0080);
        pulse(trap_start);
        wait_done(nb);
        check("R4 trap vec", pc_out, 16'h9ABC);
        check("R3 trap pcl", mem[idx(16'h0080)], 8'h00);
        check("R3 trap flags", mem[idx(16'h007A)], 8'h00);
        check("R5 trap ccr", ccr_out, 8'h10);
        check("R2 trap sp", sp_out, 16'h0079);
    endtask

    task automatic t_mask;
        int nb;
        mem[idx(16'hFFF8)] = 8'h55; mem[idx(16'hFFF9)] = 8'h66;
        mem[idx(16'hFFFE)] = 8'h77; mem[idx(16'hFFFF)] = 8'h88;
        set_regs(16'h2000, 16'h0, 8'h0, 8'h0, 8'h10, 16'h0060);
        irq_req = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 masked irq", busy, 0);
        ccr_in = 8'h00;
        @(negedge clk);
        irq_req = 1'b0;
        wait_done(nb);
        check("R4 irq vec", pc_out, 16'h5566);
        @(negedge clk);
        ccr_in = 8'h10;
        pulse(nmi_req);
        check("R6 nmi while masked", busy, 1);
        wait_done(nb);
        check("R4 nmi vec", pc_out, 16'h7788);
        check("R5 nmi ccr", ccr_out, 8'h10);
    endtask

    task automatic t_nmi_latch;
        int nb;
        set_regs(16'h3000, 16'h0, 8'h0, 8'h0, 8'h00, 16'h0050);
        pulse(swi_start);
        repeat (3) @(negedge clk);
        pulse(nmi_req);
        wait_done(nb);
        check("R8 first is swi", pc_out, 16'h8010);
        @(negedge clk);
        check("R8 nmi follows", busy, 1);
        wait_done(nb);
        check("R8 nmi vec", pc_out, 16'h7788);
        @(negedge clk);
    endtask

    task automatic t_priority;
        int nb;
        set_regs(16'h0, 16'h0, 8'h0, 8'h0, 8'h00, 16'h0040);
        swi_start = 1; trap_start = 1;
        @(negedge clk);
        swi_start = 0; trap_start = 0;
        wait_done(nb);
        check("R10 swi over trap", pc_out, 16'h8010);
        @(negedge clk);
        irq_req = 1; swi_start = 1;
        @(negedge clk);
        irq_req = 0; swi_start = 0;
        wait_done(nb);
        check("R10 irq over swi", pc_out, 16'h5566);
        @(negedge clk);
        pulse(swi_start);
        repeat (2) @(negedge clk);
        pulse(trap_start);
        wait_done(nb);
        @(negedge clk);
        check("R10 start while busy dropped", busy, 0);
        check("R10 no trap vector", pc_out, 16'h8010);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_swi_entry();
        t_rti();
        t_trap();
        t_mask();
        t_nmi_latch();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule